// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives a slow management clock from one of four candidate input clocks. A 2-bit select field chooses which clock feeds the divider. An 8-bit divide code sets the ratio in steps of one half. Because a half-integer ratio needs output edges on both edges of the source, the divider keeps one state flop on the rising edge of the source and one on the falling edge. The output is the XOR of those two flops, so every output edge comes from a flop.

The code is read only when the internal period counter wraps. A change of code therefore never cuts an output pulse short. A change of select drives the output low at once. The new select value then passes through a two-stage synchronizer in the new clock's domain, and a short hold follows before division restarts. A one-cycle flag marks each cycle in which a changed ratio is loaded. A typical use is a 12 MHz master clock with code 0x50, which gives a management clock near 300 kHz.

Top module: `hs_clkdiv`

## Requirements
- R1: While rst_n is low, div_clk and cfg_upd are 0. The applied code comes out of reset as 0x50, so presenting 0x50 after reset causes no cfg_upd pulse and gives a period of 40.5 source periods.
- R2: sel picks src_clk[sel] as the source. 0 is the master clock, 1 the internal oscillator, 2 the DAC clock and 3 the ADC clock.
- R3: For codes 2 to 255 the div_clk period is (code + 1) / 2 periods of the selected source.
- R4: Let M = max(code + 1, 2). div_clk is high for ceil(M / 2) source half-periods and low for the rest of the period.
- R5: cfg_upd is high for exactly one source cycle when a code giving a different ratio is loaded. It is not raised when the loaded ratio is unchanged.
- R6: div_code is sampled only when the period counter wraps, at an output period boundary. Code changes between samples have no effect, and across a change no high or low pulse is shorter than the shorter one of the old and new ratios.
- R7: When sel changes, div_clk goes low at once. It shows no rising edge for at least two cycles of the new source, and then divides the new source.
- R8: Codes 0x00 and 0x01 both give ratio 1. The selected source passes through to div_clk, with period equal to the source period and 50 % duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 4 | Candidate source clocks, indexed by sel |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 2 | Source select |
| div_code | input | 8 | Divide code, ratio = (code + 1) / 2 |
| div_clk | output | 1 | Divided clock |
| cfg_upd | output | 1 | One source cycle pulse when a new ratio is loaded |

## Verification
The bench measures rise-to-rise periods and high times for the unity codes 0 and 1, for odd and even codes, and for the extreme code 0xFF, on every source. A design that mishandled the half-step would show a period or duty off by one half-period. The bench also changes the code in the middle of a period and checks the narrowest pulses, which catches a design that reloads at once and emits a runt pulse. A code flicker that ends before the next wrap must leave the ratio and cfg_upd untouched; a design that sampled every cycle would fail this. Finally the bench switches the source while the output is high and checks that the output drops at once and that the first new rising edge is late enough.

// File: rtl/hs_clkdiv_pkg.sv
`timescale 1ns/1ps
package hs_clkdiv_pkg;

   // Source select encoding seen at the sel port
   typedef enum logic [1:0] {
      SRC_MASTER = 2'd0,
      SRC_OSC    = 2'd1,
      SRC_DAC    = 2'd2,
      SRC_ADC    = 2'd3
   } src_sel_e;

   localparam int unsigned DEF_CODE_W   = 8;
   localparam int unsigned DEF_SEL_W    = 2;
   localparam int unsigned DEF_HOLD_CYC = 2;

endpackage

// File: rtl/hs_srcmux.sv
`timescale 1ns/1ps
module hs_srcmux #(
   parameter int unsigned NSRC  = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [NSRC-1:0]  src,
   input  logic [SEL_W-1:0] sel,
   output logic             clk_o
);

   generate
      if (NSRC == (1 << SEL_W)) begin : g_full
         assign clk_o = src[sel];
      end else begin : g_partial
         // Out-of-range select values park the clock low
         assign clk_o = (32'(sel) < NSRC) ? src[sel] : 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hs_handover.sv
`timescale 1ns/1ps
module hs_handover #(
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned HOLD_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             busy,
   output logic             out_en
);

   localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);

   logic [SEL_W-1:0]  sel_s1, sel_s2, sel_cur;
   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_s1  <= '0;
         sel_s2  <= '0;
         sel_cur <= '0;
         hold_q  <= HOLD_W'(HOLD_CYC);
      end else begin
         sel_s1 <= sel;
         sel_s2 <= sel_s1;
         if (sel_s2 != sel_cur) begin
            sel_cur <= sel_s2;
            hold_q  <= HOLD_W'(HOLD_CYC);
         end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

   assign busy   = (hold_q != '0) || (sel_s2 != sel_cur);
   // Raw select compare drops the output the moment sel moves
   assign out_en = !busy && (sel == sel_cur);

endmodule

// File: rtl/hs_halfstep_core.sv
`timescale 1ns/1ps
module hs_halfstep_core #(
   parameter int unsigned         CODE_W     = 8,
   parameter logic [CODE_W-1:0]   RESET_CODE = 8'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [CODE_W-1:0] code,
   output logic              core_clk,
   output logic              upd,
   output logic [CODE_W:0]   m_cur,
   output logic [CODE_W:0]   cnt_cur
);

   localparam int unsigned M_W = CODE_W + 1;

   // Number of source half-periods in one output period
   function automatic logic [M_W-1:0] halves(input logic [CODE_W-1:0] c);
      if (c <= CODE_W'(1)) return M_W'(2);
      return {1'b0, c} + M_W'(1);
   endfunction

   // Whether half-slot h of a double output period is a high slot
   function automatic logic slot_hi(input logic [M_W:0] h, input logic [M_W-1:0] m);
      logic [M_W:0] mm, hm;
      mm = {1'b0, m};
      hm = (h >= mm) ? (h - mm) : h;
      return hm < ((mm + 1'b1) >> 1);
   endfunction

   localparam logic [M_W-1:0] RST_M = halves(RESET_CODE);

   logic [M_W-1:0] m_q, cnt_q, m_ld, m_nx, cnt_nx;
   logic           wrap, p_q, n_q, upd_q;

   assign wrap   = (cnt_q == m_q - 1'b1);
   assign m_ld   = halves(code);
   assign m_nx   = wrap ? m_ld : m_q;
   assign cnt_nx = wrap ? '0 : cnt_q + 1'b1;

   // Rising-edge half: counter, ratio register, rising flop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q   <= RST_M;
         cnt_q <= RST_M - 1'b1;
         p_q   <= 1'b0;
         upd_q <= 1'b0;
      end else if (busy) begin
         cnt_q <= m_q - 1'b1;
         p_q   <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         m_q   <= m_nx;
         cnt_q <= cnt_nx;
         p_q   <= slot_hi({cnt_nx, 1'b0}, m_nx) ^ n_q;
         upd_q <= wrap && (m_ld != m_q);
      end
   end

   // Falling-edge half: covers the odd half-slots
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= 1'b0;
      end else if (busy) begin
         n_q <= 1'b0;
      end else begin
         n_q <= slot_hi({cnt_q, 1'b1}, m_q) ^ p_q;
      end
   end

   assign core_clk = p_q ^ n_q;
   assign upd      = upd_q;
   assign m_cur    = m_q;
   assign cnt_cur  = cnt_q;

endmodule

// File: rtl/hs_clkdiv.sv
`timescale 1ns/1ps
module hs_clkdiv #(
   parameter int unsigned       NSRC         = 4,
   parameter int unsigned       SEL_W        = hs_clkdiv_pkg::DEF_SEL_W,
   parameter int unsigned       CODE_W       = hs_clkdiv_pkg::DEF_CODE_W,
   parameter logic [CODE_W-1:0] RESET_CODE   = 8'h50,
   parameter int unsigned       HOLD_CYC     = hs_clkdiv_pkg::DEF_HOLD_CYC,
   parameter bit                BYPASS_UNITY = 1'b1
) (
   input  logic [NSRC-1:0]   src_clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic [CODE_W-1:0] div_code,
   output logic              div_clk,
   output logic              cfg_upd
);

   localparam int unsigned M_W = CODE_W + 1;

   generate
      if (CODE_W < 2) begin : g_bad_code_w
         $error("hs_clkdiv: CODE_W must be 2 or more");
      end
      if (NSRC > (1 << SEL_W) || NSRC < 1) begin : g_bad_nsrc
         $error("hs_clkdiv: NSRC must fit the select width");
      end
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("hs_clkdiv: HOLD_CYC must be 2 or more");
      end
   endgenerate

   logic           mux_clk, busy, out_en, core_clk, pre_clk;
   logic [M_W-1:0] m_cur, cnt_cur;

   hs_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
      .src   (src_clk),
      .sel   (sel),
      .clk_o (mux_clk)
   );

   hs_handover #(.SEL_W(SEL_W), .HOLD_CYC(HOLD_CYC)) u_hand (
      .clk    (mux_clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .busy   (busy),
      .out_en (out_en)
   );

   hs_halfstep_core #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_core (
      .clk      (mux_clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .code     (div_code),
      .core_clk (core_clk),
      .upd      (cfg_upd),
      .m_cur    (m_cur),
      .cnt_cur  (cnt_cur)
   );

   generate
      if (BYPASS_UNITY) begin : g_bypass
         assign pre_clk = (m_cur == M_W'(2)) ? mux_clk : core_clk;
      end else begin : g_no_bypass
         assign pre_clk = core_clk;
      end
   endgenerate

   assign div_clk = pre_clk & out_en;

endmodule

// File: rtl/hs_clkdiv_chk.sv
`timescale 1ns/1ps
module hs_clkdiv_chk #(
   parameter int unsigned M_W = 9
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           cfg_upd,
   input logic [M_W-1:0] m_cur,
   input logic [M_W-1:0] cnt_cur
);

   // R3: the half-slot counter stays inside the loaded period
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_cur < m_cur);

   // R6: the ratio register moves only on a counter wrap
   a_r6_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (cnt_cur != m_cur - 1'b1)) |=> $stable(m_cur));

   // R5: the update flag never lasts more than one cycle
   a_r5_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_upd |=> !cfg_upd);

   // R7: no update is flagged straight after a handover cycle
   a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !cfg_upd);

endmodule

bind hs_clkdiv hs_clkdiv_chk #(.M_W(M_W)) u_chk (
   .clk     (mux_clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .cfg_upd (cfg_upd),
   .m_cur   (m_cur),
   .cnt_cur (cnt_cur)
);

// File: tb/tb_hs_clkdiv.sv
`timescale 1ns/1ps
module tb_hs_clkdiv;

   logic       c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
   logic [3:0] src_clk;
   logic       rst_n;
   logic [1:0] sel;
   logic [7:0] div_code;
   logic       div_clk, cfg_upd;

   assign src_clk = {c3, c2, c1, c0};

   initial forever #4 c0 = ~c0;   // 125 MHz master
   initial forever #5 c1 = ~c1;
   initial forever #6 c2 = ~c2;
   initial forever #3 c3 = ~c3;

   hs_clkdiv dut (
      .src_clk  (src_clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .div_code (div_code),
      .div_clk  (div_clk),
      .cfg_upd  (cfg_upd)
   );

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;
   int upd_pulses = 0;

   always @(posedge cfg_upd) upd_pulses++;

   // Pulse-width monitor
   real t_rise = 0.0, t_fall = 0.0, mon_start = 0.0;
   real hi_min = 1.0e9, lo_min = 1.0e9;
   bit  mon = 0;
   always @(posedge div_clk) begin
      if (mon && t_fall >= mon_start && ($realtime - t_fall) < lo_min) lo_min = $realtime - t_fall;
      t_rise = $realtime;
   end
   always @(negedge div_clk) begin
      if (mon && t_rise >= mon_start && ($realtime - t_rise) < hi_min) hi_min = $realtime - t_rise;
      t_fall = $realtime;
   end

   // Stimulus table: {sel, code}
   localparam int NV = 12;
   localparam logic [9:0] VEC [NV] = '{
      {2'd0, 8'h00}, {2'd0, 8'h01}, {2'd0, 8'h02}, {2'd0, 8'h03},
      {2'd0, 8'h50}, {2'd0, 8'hFF}, {2'd1, 8'h04}, {2'd2, 8'h05},
      {2'd3, 8'hFD}, {2'd3, 8'hFE}, {2'd1, 8'h01}, {2'd2, 8'h02}
   };

   function automatic real tsrc(input int s);
      case (s)
         0: return 8.0;
         1: return 10.0;
         2: return 12.0;
         default: return 6.0;
      endcase
   endfunction

   function automatic int m_of(input int code);
      return (code <= 1) ? 2 : code + 1;
   endfunction

   task automatic chk_r(input string req, input string what, input real act, input real exp);
      n_checks++;
      if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
         n_errs++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
      end
   endtask

   task automatic chk_i(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic measure(output real per1, output real per2, output real hi);
      real r0, f0, r1, r2;
      @(posedge div_clk) r0 = $realtime;
      @(negedge div_clk) f0 = $realtime;
      @(posedge div_clk) r1 = $realtime;
      @(posedge div_clk) r2 = $realtime;
      per1 = r1 - r0;
      per2 = r2 - r1;
      hi   = f0 - r0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL R3 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      real p1, p2, hi, t, pt, ts, tr;
      int  m, pm;
      string rq;
      rst_n    = 1'b0;
      sel      = 2'd0;
      div_code = 8'h50;
      #31;
      chk_i("R1", "div_clk in reset", int'(div_clk), 0);
      chk_i("R1", "cfg_upd in reset", int'(cfg_upd), 0);
      upd_pulses = 0;
      #10 rst_n = 1'b1;
      #((81 * 2 + 20) * 8.0);
      chk_i("R1", "update pulses for reset code", upd_pulses, 0);
      measure(p1, p2, hi);
      chk_r("R1", "period of reset code", p1, 324.0);
      chk_r("R4", "high time of reset code", hi, 164.0);

      // Table walk
      pm = 81;
      pt = 8.0;
      for (int i = 0; i < NV; i++) begin
         sel      = VEC[i][9:8];
         div_code = VEC[i][7:0];
         t  = tsrc(int'(VEC[i][9:8]));
         m  = m_of(int'(VEC[i][7:0]));
         #(pm * pt + (2 * m + 12) * t);
         measure(p1, p2, hi);
         rq = (m == 2) ? "R8" : "R3";
         chk_r(rq, $sformatf("period A (R2 sel %0d code %0h)", VEC[i][9:8], VEC[i][7:0]), p1, m * t / 2.0);
         chk_r(rq, $sformatf("period B (R2 sel %0d code %0h)", VEC[i][9:8], VEC[i][7:0]), p2, m * t / 2.0);
         chk_r("R4", $sformatf("high time sel %0d code %0h", VEC[i][9:8], VEC[i][7:0]), hi, ((m + 1) / 2) * t / 2.0);
         pm = m;
         pt = t;
      end

      // R5: one pulse per changed ratio
      sel      = 2'd0;
      div_code = 8'h04;
      #(pm * pt + 40 * 8.0);
      upd_pulses = 0;
      div_code = 8'h0B;
      #((5 + 24 + 12) * 8.0);
      chk_i("R5", "update pulses for changed code", upd_pulses, 1);

      // R6: flicker between wraps is ignored
      upd_pulses = 0;
      @(negedge c0);
      #1 div_code = 8'h20;
      #2 div_code = 8'h0B;
      #(40 * 8.0);
      chk_i("R6", "update pulses after flicker", upd_pulses, 0);
      measure(p1, p2, hi);
      chk_r("R6", "period after flicker", p1, 48.0);

      // R6: mid-period change leaves no short pulse
      div_code = 8'h04;
      #(12 * 8.0 + 30 * 8.0);
      mon_start = $realtime;
      mon = 1;
      @(posedge div_clk);
      #13 div_code = 8'h0B;
      #((5 + 24 + 12) * 8.0);
      mon = 0;
      chk_r("R6", "narrowest high pulse", hi_min, 12.0);
      chk_r("R6", "narrowest low pulse", lo_min, 8.0);

      // R7: source handover
      div_code = 8'h03;
      #(12 * 8.0 + 20 * 8.0);
      @(posedge div_clk);
      #2;
      ts  = $realtime;
      sel = 2'd2;
      #1;
      chk_i("R7", "output low right after select change", int'(div_clk), 0);
      @(posedge div_clk) tr = $realtime;
      chk_i("R7", "first rise after two new cycles", int'((tr - ts) >= 24.0), 1);
      measure(p1, p2, hi);
      chk_r("R7", "period on new source", p1, 24.0);

      done = 1;
      summary();
      $finish;
   end

endmodule